// File: doc/BRIEF.md
# Vectored Interrupt Controller with Register Interface

This block gathers up to 32 interrupt request lines and presents one interrupt line to a processor. Each request line has a sense that is fixed when the block is built. A line can be edge sensed, where a rising edge latches a request, or level sensed, where the request is latched on every cycle the line is high. Latched requests sit in a status word. An enable word masks them, and the result is the pending word.

Software reaches the block through a plain read/write strobe port with a byte address. It can change enable bits without a read-modify-write by using a write-one-to-set alias and a write-one-to-clear alias. It retires requests by writing ones to an acknowledge address. A vector address returns the number of the pending request with the highest priority, and software uses that number directly to pick a handler. A two-bit master word does two things: bit 0 lets the output line assert, and bit 1 lets the hardware lines be latched at all.

Top module: `irqc_top`

## Requirements
- R1: After reset the status, enable and master words are zero, the vector reads 0xFFFFFFFF and `irq_out` is low.
- R2: Reads use byte offsets. Offset 0 is status, 4 is pending, 8 is enable (read/write), 24 is vector and 28 is master (bits 1:0). Offsets 12 (acknowledge), 16 (set-enable) and 20 (clear-enable) are write-only and read as 0. Read data appears on `rdata` in the cycle after `rd_en`.
- R3: A write to offset 16 sets every enable bit whose data bit is 1 and leaves the other enable bits as they were.
- R4: A write to offset 20 clears every enable bit whose data bit is 1 and leaves the other enable bits as they were.
- R5: A write to offset 12 clears every status bit whose data bit is 1. Writing 0xFFFFFFFF clears all of them.
- R6: A line whose bit in `EDGE_MASK` is 1 is edge sensed. Only a rising edge, seen against a registered copy of the line, sets its status bit. Holding the line high does not set the bit again after it has been acknowledged.
- R7: A line whose bit in `EDGE_MASK` is 0 is level sensed. It sets its status bit on every cycle it is high, so acknowledging it while it is still high leaves the bit set.
- R8: While master bit 1 is 0, no input line sets a status bit.
- R9: If an acknowledge and a new request for the same bit arrive in the same cycle, the status bit stays set.
- R10: The pending word at offset 4 reads as status AND enable.
- R11: The vector reads the index of the lowest-numbered pending bit, or 0xFFFFFFFF when no bit is pending.
- R12: `irq_out` is high exactly when master bit 0 is 1 and at least one pending bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | NUM_IRQ | Interrupt request lines |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 5 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered |
| irq_out | output | 1 | Interrupt line to the processor |

## Verification
The bench builds the block with its defaults: NUM_IRQ of 32 and an EDGE_MASK of 0x0000FFFF, which makes lines 0 to 15 edge sensed and lines 16 to 31 level sensed. With that split, one build covers both capture kinds. The bench checks the contrast between an acknowledged edge line that is held high, which stays clear, and an acknowledged level line that is held high, which sets again. The priority chain runs across both halves: lines 2, 7 and 20 are retired one at a time.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int REG_W   = 32;
    localparam int ADDR_W  = 5;
    localparam int SEL_LSB = 2;
    localparam int SEL_W   = ADDR_W - SEL_LSB;

    // Word index of each register; the byte offset is the index times four.
    typedef enum logic [SEL_W-1:0] {
        RG_STATUS = 3'd0,
        RG_PEND   = 3'd1,
        RG_ENABLE = 3'd2,
        RG_ACK    = 3'd3,
        RG_SETEN  = 3'd4,
        RG_CLREN  = 3'd5,
        RG_VECTOR = 3'd6,
        RG_MASTER = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic hw_capture;   // bit 1
        logic out_en;       // bit 0
    } master_t;

    typedef struct packed {
        logic wr_enable;
        logic wr_ack;
        logic wr_set;
        logic wr_clr;
        logic wr_master;
    } wr_dec_t;

    function automatic reg_sel_e sel_of(input logic [ADDR_W-1:0] byte_addr);
        return reg_sel_e'(byte_addr[ADDR_W-1:SEL_LSB]);
    endfunction

    function automatic wr_dec_t decode_wr(input logic wr, input reg_sel_e sel);
        wr_dec_t d;
        d.wr_enable = wr && (sel == RG_ENABLE);
        d.wr_ack    = wr && (sel == RG_ACK);
        d.wr_set    = wr && (sel == RG_SETEN);
        d.wr_clr    = wr && (sel == RG_CLREN);
        d.wr_master = wr && (sel == RG_MASTER);
        return d;
    endfunction

endpackage

// File: rtl/irqc_capture.sv
module irqc_capture #(
    parameter int          NUM_IRQ   = 32,
    parameter logic [31:0] EDGE_MASK = 32'h0000_FFFF
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_IRQ-1:0] irq_in,
    input  logic               capture_en,
    input  logic               ack_stb,
    input  logic [NUM_IRQ-1:0] ack_bits,
    output logic [NUM_IRQ-1:0] status
);

    logic [NUM_IRQ-1:0] prev_q;
    logic [NUM_IRQ-1:0] req;
    logic [NUM_IRQ-1:0] clr;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= irq_in;
    end

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_sense
        if (EDGE_MASK[i]) begin : g_edge
            assign req[i] = capture_en & irq_in[i] & ~prev_q[i];
        end else begin : g_level
            assign req[i] = capture_en & irq_in[i];
        end
    end

    assign clr = ack_stb ? ack_bits : '0;

    // A new request wins over an acknowledge landing in the same cycle.
    always_ff @(posedge clk) begin
        if (rst) status <= '0;
        else     status <= (status & ~clr) | req;
    end

endmodule

// File: rtl/irqc_ctrl.sv
module irqc_ctrl
    import irqc_pkg::*;
#(
    parameter int NUM_IRQ = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  wr_dec_t            wdec,
    input  logic [REG_W-1:0]   wdata,
    output logic [NUM_IRQ-1:0] enable,
    output master_t            master
);

    logic [NUM_IRQ-1:0] wbits;
    logic [NUM_IRQ-1:0] enable_d;

    assign wbits = wdata[NUM_IRQ-1:0];

    always_comb begin
        enable_d = enable;
        if (wdec.wr_enable) enable_d = wbits;
        if (wdec.wr_set)    enable_d = enable | wbits;
        if (wdec.wr_clr)    enable_d = enable & ~wbits;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            enable <= '0;
            master <= '0;
        end else begin
            enable <= enable_d;
            if (wdec.wr_master) master <= master_t'(wdata[1:0]);
        end
    end

endmodule

// File: rtl/irqc_prio.sv
module irqc_prio
    import irqc_pkg::*;
#(
    parameter int NUM_IRQ = 32
) (
    input  logic [NUM_IRQ-1:0] pending,
    output logic [REG_W-1:0]   vector
);

    // Scan from the top so that the lowest index is the last one assigned.
    always_comb begin
        vector = '1;
        for (int i = NUM_IRQ - 1; i >= 0; i--) begin
            if (pending[i]) vector = REG_W'(i);
        end
    end

endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
#(
    parameter int          NUM_IRQ   = 32,
    parameter logic [31:0] EDGE_MASK = 32'h0000_FFFF
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_IRQ-1:0] irq_in,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [4:0]         addr,
    input  logic [31:0]        wdata,
    output logic [31:0]        rdata,
    output logic               irq_out
);

    reg_sel_e           sel;
    wr_dec_t            wdec;
    logic [NUM_IRQ-1:0] status_q;
    logic [NUM_IRQ-1:0] enable_q;
    logic [NUM_IRQ-1:0] pending_w;
    master_t            master_q;
    logic [REG_W-1:0]   vector_w;
    logic [REG_W-1:0]   rd_mux;

    assign sel  = sel_of(addr);
    assign wdec = decode_wr(wr_en, sel);

    irqc_capture #(.NUM_IRQ(NUM_IRQ), .EDGE_MASK(EDGE_MASK)) u_cap (
        .clk        (clk),
        .rst        (rst),
        .irq_in     (irq_in),
        .capture_en (master_q.hw_capture),
        .ack_stb    (wdec.wr_ack),
        .ack_bits   (wdata[NUM_IRQ-1:0]),
        .status     (status_q)
    );

    irqc_ctrl #(.NUM_IRQ(NUM_IRQ)) u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .wdec   (wdec),
        .wdata  (wdata),
        .enable (enable_q),
        .master (master_q)
    );

    assign pending_w = status_q & enable_q;

    irqc_prio #(.NUM_IRQ(NUM_IRQ)) u_prio (
        .pending (pending_w),
        .vector  (vector_w)
    );

    assign irq_out = master_q.out_en & (|pending_w);

    always_comb begin
        unique case (sel)
            RG_STATUS: rd_mux = REG_W'(status_q);
            RG_PEND:   rd_mux = REG_W'(pending_w);
            RG_ENABLE: rd_mux = REG_W'(enable_q);
            RG_VECTOR: rd_mux = vector_w;
            RG_MASTER: rd_mux = REG_W'(master_q);
            default:   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)        rdata <= '0;
        else if (rd_en) rdata <= rd_mux;
    end

endmodule

// File: rtl/irqc_checker.sv
module irqc_checker
    import irqc_pkg::*;
#(
    parameter int NUM_IRQ = 32
) (
    input logic               clk,
    input logic               rst,
    input logic               wr_en,
    input logic [4:0]         addr,
    input logic [31:0]        wdata,
    input logic               irq_out,
    input logic [NUM_IRQ-1:0] status,
    input logic [NUM_IRQ-1:0] enable,
    input logic [1:0]         master,
    input logic [31:0]        vector
);

    // R3
    set_enable_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr[4:2] == RG_SETEN) |=>
            (enable == ($past(enable) | $past(wdata[NUM_IRQ-1:0]))));

    // R4
    clr_enable_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr[4:2] == RG_CLREN) |=>
            (enable == ($past(enable) & ~$past(wdata[NUM_IRQ-1:0]))));

    // R5
    ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr[4:2] == RG_ACK && !master[1]) |=>
            ((status & $past(wdata[NUM_IRQ-1:0])) == '0));

    // R8
    no_capture_chk: assert property (@(posedge clk) disable iff (rst)
        !master[1] |=> ((status & ~$past(status)) == '0));

    // R11
    idle_vector_chk: assert property (@(posedge clk) disable iff (rst)
        ((status & enable) == '0) |-> (vector == 32'hFFFF_FFFF));

    // R12
    out_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !master[0] |-> !irq_out);

endmodule

bind irqc_top irqc_checker #(.NUM_IRQ(NUM_IRQ)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .addr    (addr),
    .wdata   (wdata),
    .irq_out (irq_out),
    .status  (status_q),
    .enable  (enable_q),
    .master  (master_q),
    .vector  (vector_w)
);

// File: tb/irqc_top_tb_top.sv
`timescale 1ns/1ps
module irqc_top_tb_top;

    localparam logic [4:0] A_STAT = 5'd0,  A_PEND = 5'd4,  A_EN  = 5'd8,
                           A_ACK  = 5'd12, A_SET  = 5'd16, A_CLR = 5'd20,
                           A_VEC  = 5'd24, A_MST  = 5'd28;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] irq_in = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [4:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq_out;

    int checks = 0;
    int fails  = 0;
    logic        rd_d = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    irqc_top dut_i (
        .clk(clk), .rst(rst), .irq_in(irq_in), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq_out(irq_out)
    );

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    always @(posedge clk) rd_d <= rd_en && !rst;

    // Monitor: pops one expected read per completed read strobe.
    always @(negedge clk) begin
        if (rd_d) begin
            checks++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL unexpected read: actual %h expected none", rdata);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (rdata !== e) begin
                    fails++;
                    $display("FAIL %s: actual %h expected %h", t, rdata, e);
                end
            end
        end
    end

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, input logic [31:0] e, input string t);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic chk_irq(input logic e, input string t);
        @(negedge clk);
        checks++;
        if (irq_out !== e) begin
            fails++;
            $display("FAIL %s: irq_out actual %b expected %b", t, irq_out, e);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk_irq(1'b0, "R1 irq low");
        rd(A_STAT, 32'h0, "R1 status");
        rd(A_EN,   32'h0, "R1 enable");
        rd(A_MST,  32'h0, "R1 master");
        rd(A_VEC,  32'hFFFF_FFFF, "R1 vector");

        // R8 no capture with master bit 1 clear
        @(negedge clk); irq_in[3] = 1'b1;
        @(negedge clk); irq_in[3] = 1'b0;
        rd(A_STAT, 32'h0, "R8 gated capture");

        // R6 edge capture
        wr(A_MST, 32'h3);
        @(negedge clk); irq_in[3] = 1'b1;
        repeat (3) @(negedge clk);
        irq_in[3] = 1'b0;
        rd(A_STAT, 32'h8, "R6 edge status");
        rd(A_PEND, 32'h0, "R10 masked pending");
        chk_irq(1'b0, "R12 masked");

        // R3 / R10 / R11 / R12
        wr(A_SET, 32'h108);
        rd(A_EN,   32'h108, "R3 set-enable");
        rd(A_PEND, 32'h8,   "R10 pending");
        rd(A_VEC,  32'd3,   "R11 vector");
        chk_irq(1'b1, "R12 asserted");

        // R4
        wr(A_CLR, 32'h100);
        rd(A_EN, 32'h8, "R4 clear-enable");

        // R5
        wr(A_ACK, 32'h8);
        rd(A_STAT, 32'h0, "R5 ack");
        chk_irq(1'b0, "R12 after ack");

        // R7 level held through ack
        @(negedge clk); irq_in[20] = 1'b1;
        @(negedge clk);
        wr(A_ACK, 32'h0010_0000);
        rd(A_STAT, 32'h0010_0000, "R7 level re-set");
        @(negedge clk); irq_in[20] = 1'b0;
        wr(A_ACK, 32'h0010_0000);
        rd(A_STAT, 32'h0, "R7 level cleared");

        // R6 edge held through ack
        @(negedge clk); irq_in[5] = 1'b1;
        @(negedge clk);
        rd(A_STAT, 32'h20, "R6 edge set");
        wr(A_ACK, 32'h20);
        rd(A_STAT, 32'h0, "R6 held edge stays clear");
        irq_in[5] = 1'b0;

        // R11 priority across edge and level lines
        wr(A_SET, 32'hFFFF_FFFF);
        @(negedge clk); irq_in[2] = 1'b1; irq_in[7] = 1'b1; irq_in[20] = 1'b1;
        @(negedge clk); irq_in[2] = 1'b0; irq_in[7] = 1'b0;
        rd(A_VEC, 32'd2, "R11 lowest first");
        wr(A_ACK, 32'h4);
        rd(A_VEC, 32'd7, "R11 next");
        wr(A_ACK, 32'h80);
        rd(A_VEC, 32'd20, "R11 level line");
        @(negedge clk); irq_in[20] = 1'b0;
        wr(A_ACK, 32'h0010_0000);
        rd(A_VEC, 32'hFFFF_FFFF, "R11 none pending");

        // R9 ack and new edge in the same cycle
        @(negedge clk);
        irq_in[9] = 1'b1; wr_en = 1'b1; addr = A_ACK; wdata = 32'h200;
        @(negedge clk);
        wr_en = 1'b0; irq_in[9] = 1'b0;
        rd(A_STAT, 32'h200, "R9 request wins");
        rd(A_PEND, 32'h200, "R10 pending all enabled");

        // R12 / R8 master bits
        wr(A_MST, 32'h2);
        chk_irq(1'b0, "R12 out disabled");
        wr(A_MST, 32'h1);
        chk_irq(1'b1, "R12 out enabled");
        @(negedge clk); irq_in[11] = 1'b1;
        @(negedge clk); irq_in[11] = 1'b0;
        rd(A_STAT, 32'h200, "R8 capture off");
        wr(A_ACK, 32'hFFFF_FFFF);
        rd(A_STAT, 32'h0, "R5 ack all");
        chk_irq(1'b0, "R12 idle");

        // R2 map details
        wr(A_EN, 32'hF0);
        rd(A_EN,  32'hF0, "R2 enable direct write");
        rd(A_ACK, 32'h0,  "R2 write-only reads zero");
        rd(A_SET, 32'h0,  "R2 set alias reads zero");
        rd(A_MST, 32'h1,  "R2 master readback");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL R2 reads missing: actual %0d left expected 0", exp_q.size());
        end
        finish_run();
    end

endmodule